// File: doc/BRIEF.md
# Minimal Sequencing Processor Core

This block is a very small program-driven sequencer. A program counter addresses an external program memory. Each cycle the 6-bit word that comes back is decoded and executed, and the program counter moves to the address of the next instruction. The core has no arithmetic unit. Its only state is the program counter and a 4-bit output latch, so a program is simply a pattern of output values joined by jumps.

The instruction set has four opcodes. The two upper bits of a word select the operation and the four lower bits carry a location or a data value. A program can jump unconditionally, jump only when an external condition bit is high, or place a constant on the output. The remaining opcode does nothing except advance. Exactly one instruction completes on every clock edge. Changing the program changes the sequence the block produces, and the hardware stays the same.

Top module: `seq_core`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `pc_addr` and `dout` both become 0 on that edge. Reset takes priority over the instruction being presented.
- R2: An instruction word carries the opcode in bits [5:4] and the location/data field in bits [3:0].
- R3: Opcode 2'b00 (jump) loads `pc_addr` with the field on the executing edge.
- R4: Opcode 2'b01 (conditional jump) with `cond_in` = 1 loads `pc_addr` with the field.
- R5: Opcode 2'b01 with `cond_in` = 0 advances `pc_addr` by one.
- R6: Opcode 2'b10 (output) loads `dout` with the field on the executing edge and advances `pc_addr` by one.
- R7: Opcode 2'b11 (no-operation) advances `pc_addr` by one and leaves `dout` unchanged.
- R8: Advancing from address 15 gives address 0.
- R9: `dout` keeps its value on every instruction other than output (2'b10), whatever `cond_in` is.
- R10: Exactly one instruction completes per clock cycle. `pc_addr` always holds the address of the instruction that executes on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_in | input | 1 | Condition bit sampled by the conditional jump |
| pc_addr | output | 4 | Program memory address (program counter) |
| instr_data | input | 6 | Instruction word read from program memory at `pc_addr` |
| dout | output | 4 | Output register |

## Verification
The hardest case to reach from the ports is the wrap of the program counter from 15 to 0. Only the increment path can produce it, and that path has three separate sources: a fall-through conditional jump, a no-operation, and an output instruction. The stimulus gets there by first jumping to location 15 and then presenting each of these advancing instructions in turn. Reset asserted while an output instruction is presented is also checked, to confirm that reset wins over the instruction. A short stored program then runs with the condition held low and later held high, which exercises the loop-back and the taken branch in context.

// File: rtl/seq_pkg.sv
// Shared definitions for the sequencing core.
// Assumes a 2-bit opcode placed above the location/data field.
package seq_pkg;
    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_JMP = 2'b00,
        OP_JC  = 2'b01,
        OP_OUT = 2'b10,
        OP_NOP = 2'b11
    } seq_op_e;
endpackage

// File: rtl/seq_decode.sv
// Instruction decoder: splits a word into opcode and field and turns them
// into the control strobes for the program counter and the output latch.
// Assumes the opcode sits in the most significant OPC_W bits.
module seq_decode
    import seq_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic [OPC_W+FIELD_W-1:0] instr,
    input  logic                     cond,
    output logic                     take_jump,
    output logic                     load_out,
    output logic [FIELD_W-1:0]       field
);
    seq_op_e op;

    // Split the word and derive the strobes.
    always_comb begin
        op        = seq_op_e'(instr[OPC_W+FIELD_W-1:FIELD_W]);
        field     = instr[FIELD_W-1:0];
        take_jump = 1'b0;
        load_out  = 1'b0;
        case (op)
            OP_JMP:  take_jump = 1'b1;
            OP_JC:   take_jump = cond;
            OP_OUT:  load_out  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/seq_pc.sv
// Program counter: loads a jump target or advances by one, wrapping
// at the top of the address space. Synchronous active-low reset to 0.
module seq_pc #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);
    // Select the next address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (load)
            pc <= target;
        else
            pc <= pc + ADDR_W'(1);
    end
endmodule

// File: rtl/seq_outreg.sv
// Output latch: captures the data field when enabled and holds it otherwise.
// Synchronous active-low reset to 0.
module seq_outreg #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Capture on an output instruction, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/seq_core.sv
// Top of the sequencing core. It fetches from an external program memory
// at pc_addr and executes one instruction per clock. It assumes the memory
// returns the word combinationally in the same cycle, and that the field
// width equals the address width, so a location field covers the whole space.
module seq_core
    import seq_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cond_in,
    output logic [FIELD_W-1:0]       pc_addr,
    input  logic [OPC_W+FIELD_W-1:0] instr_data,
    output logic [FIELD_W-1:0]       dout
);
    localparam int ADDR_W = FIELD_W;

    logic               take_jump;
    logic               load_out;
    logic [FIELD_W-1:0] field;

    seq_decode #(.FIELD_W(FIELD_W)) u_dec (
        .instr     (instr_data),
        .cond      (cond_in),
        .take_jump (take_jump),
        .load_out  (load_out),
        .field     (field)
    );

    seq_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take_jump),
        .target (field),
        .pc     (pc_addr)
    );

    seq_outreg #(.DATA_W(FIELD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_out),
        .din   (field),
        .q     (dout)
    );
endmodule

// File: rtl/seq_core_chk.sv
// Checker for seq_core: relates the instruction and condition presented in
// one cycle to the address and output seen in the next. Attached by bind.
module seq_core_chk #(
    parameter int FIELD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cond_in,
    input logic [FIELD_W-1:0] pc_addr,
    input logic [FIELD_W+1:0] instr_data,
    input logic [FIELD_W-1:0] dout
);
    logic [1:0]         opc;
    logic [FIELD_W-1:0] fld;
    assign opc = instr_data[FIELD_W+1:FIELD_W];
    assign fld = instr_data[FIELD_W-1:0];

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_addr == '0 && dout == '0));

    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b00) |=> (pc_addr == $past(fld)));

    p_cjump_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b01 && cond_in) |=> (pc_addr == $past(fld)));

    p_cjump_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b01 && !cond_in) |=> (pc_addr == FIELD_W'($past(pc_addr) + 1)));

    p_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b10) |=> (dout == $past(fld) && pc_addr == FIELD_W'($past(pc_addr) + 1)));

    p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b11) |=> (pc_addr == FIELD_W'($past(pc_addr) + 1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != 2'b10) |=> $stable(dout));
endmodule

bind seq_core seq_core_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_in    (cond_in),
    .pc_addr    (pc_addr),
    .instr_data (instr_data),
    .dout       (dout)
);

// File: tb/tb_seq_core.sv
module tb_seq_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    localparam int WATCHDOG = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cond_in = 1'b0;
    logic [3:0] pc_addr;
    logic [5:0] instr_data;
    logic [3:0] dout;
    logic [5:0] drv_instr = 6'b110000;
    logic       use_rom = 1'b0;
    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    // Vector: {instr[5:0], cond, exp_pc[3:0], exp_dout[3:0]}, from pc=0, dout=0
    localparam logic [14:0] VEC [NVEC] = '{
        {6'b10_0101, 1'b0, 4'd1,  4'h5},  // R6 out 5
        {6'b11_0000, 1'b1, 4'd2,  4'h5},  // R7 nop
        {6'b00_1001, 1'b1, 4'd9,  4'h5},  // R3 jmp 9
        {6'b01_0011, 1'b0, 4'd10, 4'h5},  // R5 jc not taken
        {6'b01_0011, 1'b1, 4'd3,  4'h5},  // R4 jc taken
        {6'b10_1010, 1'b1, 4'd4,  4'hA},  // R6 out A
        {6'b10_0000, 1'b0, 4'd5,  4'h0},  // R6 out 0
        {6'b00_1111, 1'b0, 4'd15, 4'h0},  // R3 jmp 15
        {6'b11_1010, 1'b0, 4'd0,  4'h0},  // R8 nop wraps
        {6'b10_1111, 1'b0, 4'd1,  4'hF},  // R6 out F
        {6'b00_1111, 1'b1, 4'd15, 4'hF},  // R3 jmp 15
        {6'b01_0010, 1'b0, 4'd0,  4'hF},  // R8 jc fall-through wraps
        {6'b00_1111, 1'b0, 4'd15, 4'hF},  // R3 jmp 15
        {6'b10_0011, 1'b1, 4'd0,  4'h3},  // R8 out wraps
        {6'b00_0000, 1'b1, 4'd0,  4'h3}   // R9 jmp 0 keeps dout
    };

    // Stored program: 0 out1; 1 jc 4; 2 out2; 3 jmp 0; 4 out8; 5 jmp 5
    logic [5:0] rom [16];
    initial begin
        for (int i = 0; i < 16; i++) rom[i] = 6'b11_0000;
        rom[0] = 6'b10_0001;
        rom[1] = 6'b01_0100;
        rom[2] = 6'b10_0010;
        rom[3] = 6'b00_0000;
        rom[4] = 6'b10_1000;
        rom[5] = 6'b00_0101;
    end

    assign instr_data = use_rom ? rom[pc_addr] : drv_instr;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_in    (cond_in),
        .pc_addr    (pc_addr),
        .instr_data (instr_data),
        .dout       (dout)
    );

    task automatic check(input string req, input logic [3:0] exp_pc,
                         input logic [3:0] exp_d);
        n_checks++;
        if (pc_addr !== exp_pc || dout !== exp_d) begin
            n_fail++;
            $display("FAIL %s: pc=%0d dout=%h expected pc=%0d dout=%h",
                     req, pc_addr, dout, exp_pc, exp_d);
        end
    endtask

    task automatic step(input logic [5:0] ins, input logic c);
        drv_instr = ins;
        cond_in   = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected <= %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        step(6'b10_0111, 1'b1);
        step(6'b10_0111, 1'b1);
        check("R1 reset", 4'd0, 4'h0);
        rst_n = 1'b1;

        // R2..R10: vector table, one instruction per edge
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][14:9], VEC[v][8]);
            check($sformatf("R2/R10 vector %0d", v), VEC[v][7:4], VEC[v][3:0]);
        end

        // R1: reset overrides an output instruction mid-run
        step(6'b00_0111, 1'b0);
        check("R3 jmp 7 before reset", 4'd7, 4'h3);
        rst_n = 1'b0;
        step(6'b10_1001, 1'b0);
        check("R1 reset beats out", 4'd0, 4'h0);
        rst_n = 1'b1;

        // R9: no-op with condition high leaves dout
        step(6'b10_0110, 1'b0);
        step(6'b11_1111, 1'b1);
        check("R9 nop hold", 4'd2, 4'h6);
        step(6'b01_1100, 1'b1);
        check("R9 jc taken hold", 4'd12, 4'h6);

        // R10: stored program, condition low then high
        rst_n = 1'b0;
        step(6'b11_0000, 1'b0);
        rst_n = 1'b1;
        use_rom = 1'b1;
        step(6'b0, 1'b0); check("R10 prog out1", 4'd1, 4'h1);
        step(6'b0, 1'b0); check("R5 prog fall", 4'd2, 4'h1);
        step(6'b0, 1'b0); check("R10 prog out2", 4'd3, 4'h2);
        step(6'b0, 1'b0); check("R3 prog loop", 4'd0, 4'h2);
        step(6'b0, 1'b0); check("R10 prog out1 again", 4'd1, 4'h1);
        step(6'b0, 1'b1); check("R4 prog taken", 4'd4, 4'h1);
        step(6'b0, 1'b1); check("R6 prog out8", 4'd5, 4'h8);
        step(6'b0, 1'b0); check("R3 prog self loop", 4'd5, 4'h8);

        done = 1'b1;
        finish_run();
    end
endmodule